// File: doc/BRIEF.md
# Power Supply Supervisor Fault Controller

This block supervises a switched-mode supply from the digital side. It takes the comparator flags for over-voltage on the 3.3 V, 5 V and VCC rails, the flags for under-voltage on the 3.3 V and 5 V rails, and two flags for the power-good input: one that says it is healthy and one that says it has fallen below its low threshold. It also takes the active-low power-on request. Each input class passes through its own filter. Over- and under-voltage faults set a sticky fault latch. A fault on the power-good input only withdraws power-good.

Power-good is asserted once all conditions have been healthy for an uninterrupted delay. Under-voltage checking starts a fixed time after the power-on request is accepted, and it is masked while the power-good input sits below its low threshold. The fault latch clears a fixed time after the debounced request returns high. Both outputs are open-drain pull-down enables. A value of 1 means the pin is pulled low. A value of 0 means the pin is released to the external pull-up, and the pin then reads high.

Every delay is a parameter given in microseconds. Each delay is converted to clock cycles from `CLK_KHZ` as floor(CLK_KHZ·µs/1000), with a minimum of 1.

Top module: `pss_supervisor`

## Requirements
- R1: During and after reset, with no power-on request, both `pgood_pd_o` and `fault_pd_o` are 1 (both pins pulled low).
- R2: An over-voltage flag is accepted only once it has held a new value for N_OV = cycles(OV_GLITCH_US) consecutive clock edges. A shorter pulse has no effect on either output.
- R3: The under-voltage flags and both power-good-input flags are accepted after N_UV = cycles(UV_GLITCH_US) stable edges.
- R4: The power-on request is accepted only after N_REQ = cycles(REQ_DEBOUNCE_US) stable edges. A shorter low pulse never raises power-good.
- R5: An accepted over-voltage flag on any of the three rails drops power-good (`pgood_pd_o`=1) on the edge where it is accepted. It releases the fault pin (`fault_pd_o`=0, fault reads high) one edge later.
- R6: Once set, the fault latch stays set after the fault flag clears, for as long as the request stays active.
- R7: After the debounced request goes high, the fault latch clears N_REL+1 edges later, where N_REL = cycles(RELEASE_US).
- R8: An accepted loss of the power-good input (`pgin_ok_i`=0) drops power-good on the edge where it is accepted, and it never sets the fault latch.
- R9: Power-good rises N_PG = cycles(PG_DELAY_US) edges after the last condition became healthy. Any unhealthy condition during the count restarts it from zero.
- R10: Under-voltage faults are ignored until N_UVEN = cycles(UV_ENABLE_US) edges after the debounced request goes low. A flag already present then sets the latch one edge later.
- R11: While the accepted `pgin_low_i` is 1, under-voltage flags are ignored. When it clears, a standing under-voltage flag drops power-good at once and sets the latch one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ov_v33_i | input | 1 | 3.3 V over-voltage flag, 1 = fault |
| ov_v5_i | input | 1 | 5 V over-voltage flag, 1 = fault |
| ov_vcc_i | input | 1 | VCC over-voltage flag, 1 = fault |
| uv_v33_i | input | 1 | 3.3 V under-voltage flag, 1 = fault |
| uv_v5_i | input | 1 | 5 V under-voltage flag, 1 = fault |
| pgin_ok_i | input | 1 | Power-good input healthy, 1 = healthy |
| pgin_low_i | input | 1 | Power-good input below low threshold, 1 = below |
| pwr_req_n_i | input | 1 | Power-on request, 0 = on |
| pgood_pd_o | output | 1 | Power-good pin pull-down enable, 1 = pulled low |
| fault_pd_o | output | 1 | Fault pin pull-down enable, 0 = released (fault reads high) |

## Verification
Each result has a known latency. Power-good falls on the same edge that a filter accepts a fault. The latch follows one edge after that. Power-good rises N_PG edges after the last accepted healthy condition. The latch clears N_REL+1 edges after the request filter accepts the high level. The bench drives inputs on the falling clock edge and counts rising edges from there. It samples each output one edge before its due edge and again on it, so a result that comes early or late is caught. The bench sets its parameters so that one microsecond is one cycle, which makes every window a short, exact count.

// File: rtl/pss_pkg.sv
// Package: shared helpers for the supply supervisor.
// Assumes delays are given in microseconds and the clock in kHz.
package pss_pkg;

    // Convert a delay in microseconds into clock cycles, at least one.
    function automatic int unsigned us_to_cycles(longint unsigned khz, longint unsigned us);
        longint unsigned c;
        c = (khz * us) / 64'd1000;
        if (c == 64'd0) c = 64'd1;
        return int'(c);
    endfunction

    localparam int unsigned NUM_OV = 3;
    localparam int unsigned NUM_UV = 2;

endpackage

// File: rtl/pss_deglitch.sv
// Module: stability filter. The output takes the input value once the input
// has differed from the output for N consecutive clock edges; a shorter
// excursion is discarded. Assumes the input is already synchronous to clk.
module pss_deglitch #(
    parameter int unsigned N       = 4,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = (N < 2) ? 1 : $clog2(N + 1);

    logic [CW-1:0] cnt;
    logic          out_q;

    // Count edges of disagreement and adopt the input at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            out_q <= RST_VAL;
        end else if (raw_i == out_q) begin
            cnt <= '0;
        end else if (cnt == CW'(N - 1)) begin
            out_q <= raw_i;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign clean_o = out_q;

    // R2 and R3: an output change happens only when the run counter was full.
    a_r2_accept_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> ($past(cnt) == CW'(N - 1)));

    // R3: an accepted value equals the input sampled on that edge.
    a_r3_accept_value: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> (out_q == $past(raw_i)));

endmodule

// File: rtl/pss_hold_timer.sv
// Module: saturating delay. done_o goes high once run_i has been high for
// N consecutive edges and stays high while run_i holds; a low run_i
// restarts the count. Assumes N fits the derived counter width.
module pss_hold_timer #(
    parameter int unsigned N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(N + 1);

    logic [CW-1:0] cnt;

    // Advance while enabled, saturate at N, clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (!run_i)             cnt <= '0;
        else if (cnt != CW'(N))      cnt <= cnt + 1'b1;
    end

    assign done_o = (cnt == CW'(N));

    // R7, R9, R10: a stopped timer reports not-done on the next edge.
    a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !done_o);

endmodule

// File: rtl/pss_supervisor.sv
// Module: supply supervisor top. Filters the rail and request flags, keeps
// the sticky fault latch, times under-voltage enable, latch release and
// power-good, and drives two open-drain pull-down enables.
// Assumes all flag inputs are synchronous to clk.
module pss_supervisor #(
    parameter int unsigned CLK_KHZ         = 50000,
    parameter int unsigned OV_GLITCH_US    = 55,
    parameter int unsigned UV_GLITCH_US    = 73,
    parameter int unsigned REQ_DEBOUNCE_US = 38000,
    parameter int unsigned RELEASE_US      = 3500,
    parameter int unsigned UV_ENABLE_US    = 75000,
    parameter int unsigned PG_DELAY_US     = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ov_v33_i,
    input  logic ov_v5_i,
    input  logic ov_vcc_i,
    input  logic uv_v33_i,
    input  logic uv_v5_i,
    input  logic pgin_ok_i,
    input  logic pgin_low_i,
    input  logic pwr_req_n_i,
    output logic pgood_pd_o,
    output logic fault_pd_o
);
    import pss_pkg::*;

    localparam int unsigned N_OV   = us_to_cycles(CLK_KHZ, OV_GLITCH_US);
    localparam int unsigned N_UV   = us_to_cycles(CLK_KHZ, UV_GLITCH_US);
    localparam int unsigned N_REQ  = us_to_cycles(CLK_KHZ, REQ_DEBOUNCE_US);
    localparam int unsigned N_REL  = us_to_cycles(CLK_KHZ, RELEASE_US);
    localparam int unsigned N_UVEN = us_to_cycles(CLK_KHZ, UV_ENABLE_US);
    localparam int unsigned N_PG   = us_to_cycles(CLK_KHZ, PG_DELAY_US);

    logic [NUM_OV-1:0] ov_raw, ov_f;
    logic [NUM_UV-1:0] uv_raw, uv_f;
    logic pgin_ok_f, pgin_low_f, req_n_f, req_on;
    logic uv_en, rel_done, pg_done;
    logic ov_fault, uv_fault, healthy, pg, fault_q;

    assign ov_raw = {ov_vcc_i, ov_v5_i, ov_v33_i};
    assign uv_raw = {uv_v5_i, uv_v33_i};

    // One short filter per over-voltage rail.
    for (genvar i = 0; i < NUM_OV; i++) begin : g_ov
        pss_deglitch #(.N(N_OV), .RST_VAL(1'b0)) u_flt (
            .clk(clk), .rst_n(rst_n), .raw_i(ov_raw[i]), .clean_o(ov_f[i]));
    end

    // One longer filter per under-voltage rail.
    for (genvar i = 0; i < NUM_UV; i++) begin : g_uv
        pss_deglitch #(.N(N_UV), .RST_VAL(1'b0)) u_flt (
            .clk(clk), .rst_n(rst_n), .raw_i(uv_raw[i]), .clean_o(uv_f[i]));
    end

    pss_deglitch #(.N(N_UV), .RST_VAL(1'b0)) u_pgin_ok (
        .clk(clk), .rst_n(rst_n), .raw_i(pgin_ok_i), .clean_o(pgin_ok_f));

    pss_deglitch #(.N(N_UV), .RST_VAL(1'b1)) u_pgin_low (
        .clk(clk), .rst_n(rst_n), .raw_i(pgin_low_i), .clean_o(pgin_low_f));

    pss_deglitch #(.N(N_REQ), .RST_VAL(1'b1)) u_req (
        .clk(clk), .rst_n(rst_n), .raw_i(pwr_req_n_i), .clean_o(req_n_f));

    assign req_on = ~req_n_f;

    // Under-voltage checking opens a fixed time after the request is accepted.
    pss_hold_timer #(.N(N_UVEN)) u_uv_en (
        .clk(clk), .rst_n(rst_n), .run_i(req_on), .done_o(uv_en));

    // Latch release runs while the accepted request is inactive.
    pss_hold_timer #(.N(N_REL)) u_release (
        .clk(clk), .rst_n(rst_n), .run_i(req_n_f), .done_o(rel_done));

    // Fault classification for the latch and for power-good.
    always_comb begin
        ov_fault = |ov_f;
        uv_fault = uv_en & ~pgin_low_f & (|uv_f);
        healthy  = req_on & pgin_ok_f & ~fault_q & ~ov_fault & ~uv_fault;
    end

    // Sticky fault latch: a set wins over the delayed release.
    always_ff @(posedge clk) begin
        if (!rst_n)                    fault_q <= 1'b0;
        else if (ov_fault || uv_fault) fault_q <= 1'b1;
        else if (rel_done)             fault_q <= 1'b0;
    end

    // Power-good qualification delay, restarted by any unhealthy cycle.
    pss_hold_timer #(.N(N_PG)) u_pg (
        .clk(clk), .rst_n(rst_n), .run_i(healthy), .done_o(pg_done));

    assign pg         = healthy & pg_done;
    assign pgood_pd_o = ~pg;
    assign fault_pd_o = ~fault_q;

    // R5: an accepted over-voltage flag sets the latch on the next edge.
    a_r5_ov_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ov_fault |=> fault_q);

    // R6: without a release, a set latch stays set.
    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !rel_done) |=> fault_q);

    // R7: the latch falls only after the release delay has completed.
    a_r7_clear_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(rel_done));

    // R9: power-good rises only after a cycle that was already healthy.
    a_r9_pg_after_health: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg) |-> $past(healthy));

endmodule

// File: tb/sim_pss_supervisor.sv
// Directed bench: 1 kHz per MHz scaling so one microsecond is one cycle.
module sim_pss_supervisor;
    localparam int N_OV = 5, N_UV = 7, N_REQ = 20, N_REL = 10, N_UVEN = 30, N_PG = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ov_v33 = 0, ov_v5 = 0, ov_vcc = 0, uv_v33 = 0, uv_v5 = 0;
    logic pgin_ok = 1, pgin_low = 0, req_n = 1;
    logic pgood_pd, fault_pd;
    int   n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    pss_supervisor #(
        .CLK_KHZ(1000), .OV_GLITCH_US(N_OV), .UV_GLITCH_US(N_UV),
        .REQ_DEBOUNCE_US(N_REQ), .RELEASE_US(N_REL),
        .UV_ENABLE_US(N_UVEN), .PG_DELAY_US(N_PG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ov_v33_i(ov_v33), .ov_v5_i(ov_v5),
        .ov_vcc_i(ov_vcc), .uv_v33_i(uv_v33), .uv_v5_i(uv_v5),
        .pgin_ok_i(pgin_ok), .pgin_low_i(pgin_low), .pwr_req_n_i(req_n),
        .pgood_pd_o(pgood_pd), .fault_pd_o(fault_pd));

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(logic got, logic exp, string req, string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic go_off();
        req_n = 1; ov_v33 = 0; ov_v5 = 0; ov_vcc = 0; uv_v33 = 0; uv_v5 = 0;
        pgin_ok = 1; pgin_low = 0;
        tick(N_REQ + N_REL + N_UV + 5);
    endtask

    task automatic go_on();
        req_n = 0;
        tick(N_REQ + N_PG + 2);
        chk(pgood_pd, 1'b0, "R9", "power-good up after power-on");
    endtask

    task automatic t_reset();
        chk(pgood_pd, 1'b1, "R1", "pgood pulled in reset");
        chk(fault_pd, 1'b1, "R1", "fault pulled in reset");
        rst_n = 1;
        tick(N_UV + 5);
        chk(pgood_pd, 1'b1, "R1", "pgood pulled after reset");
        chk(fault_pd, 1'b1, "R1", "fault pulled after reset");
    endtask

    task automatic t_debounce();
        req_n = 0;
        tick(N_REQ - 1);
        req_n = 1;
        tick(N_REQ + N_PG + 5);
        chk(pgood_pd, 1'b1, "R4", "short request pulse ignored");
    endtask

    task automatic t_pg_delay();
        req_n = 0;
        tick(N_REQ + N_PG - 1);
        chk(pgood_pd, 1'b1, "R9", "pgood one edge before due");
        tick(1);
        chk(pgood_pd, 1'b0, "R9", "pgood on due edge");
        chk(fault_pd, 1'b1, "R4", "no fault after accepted request");
    endtask

    task automatic t_ov_glitch();
        ov_v5 = 1;
        tick(N_OV - 1);
        ov_v5 = 0;
        tick(10);
        chk(pgood_pd, 1'b0, "R2", "short ov pulse keeps pgood");
        chk(fault_pd, 1'b1, "R2", "short ov pulse no latch");
    endtask

    task automatic t_ov(int rail);
        go_on();
        case (rail)
            0: ov_v33 = 1;
            1: ov_v5 = 1;
            default: ov_vcc = 1;
        endcase
        tick(N_OV - 1);
        chk(pgood_pd, 1'b0, "R2", "ov not yet accepted");
        tick(1);
        chk(pgood_pd, 1'b1, "R5", "ov drops pgood on acceptance");
        chk(fault_pd, 1'b1, "R5", "latch not yet set");
        tick(1);
        chk(fault_pd, 1'b0, "R5", "latch set one edge later");
        ov_v33 = 0; ov_v5 = 0; ov_vcc = 0;
        tick(20);
        chk(fault_pd, 1'b0, "R6", "latch holds after ov clears");
        chk(pgood_pd, 1'b1, "R6", "pgood held down by latch");
        req_n = 1;
        tick(N_REQ + N_REL);
        chk(fault_pd, 1'b0, "R7", "latch before release edge");
        tick(1);
        chk(fault_pd, 1'b1, "R7", "latch cleared on release edge");
        go_off();
    endtask

    task automatic t_pgin_fault();
        go_on();
        pgin_ok = 0;
        tick(N_UV - 1);
        chk(pgood_pd, 1'b0, "R3", "pgin loss not yet accepted");
        tick(1);
        chk(pgood_pd, 1'b1, "R8", "pgin loss drops pgood");
        tick(20);
        chk(fault_pd, 1'b1, "R8", "pgin loss leaves latch clear");
        pgin_ok = 1;
        tick(N_UV + N_PG - 1);
        chk(pgood_pd, 1'b1, "R9", "pgood before due after pgin back");
        tick(1);
        chk(pgood_pd, 1'b0, "R9", "pgood due after pgin back");
    endtask

    task automatic t_pg_restart();
        pgin_ok = 0;
        tick(N_UV + 2);
        pgin_ok = 1;
        tick(N_UV + 20);
        chk(pgood_pd, 1'b1, "R9", "pgood still counting");
        pgin_ok = 0;
        tick(N_UV + 1);
        pgin_ok = 1;
        tick(N_UV + N_PG - 1);
        chk(pgood_pd, 1'b1, "R9", "count restarted in full");
        tick(1);
        chk(pgood_pd, 1'b0, "R9", "pgood after full restart");
        go_off();
    endtask

    task automatic t_uv_enable();
        uv_v33 = 1;
        req_n  = 0;
        tick(N_REQ + N_UVEN);
        chk(fault_pd, 1'b1, "R10", "uv ignored before enable");
        tick(1);
        chk(fault_pd, 1'b0, "R10", "uv latches after enable");
        chk(pgood_pd, 1'b1, "R10", "pgood never rose");
        go_off();
    endtask

    task automatic t_uv_mask();
        go_on();
        pgin_low = 1;
        tick(N_UV + 2);
        uv_v5 = 1;
        tick(N_UV + 10);
        chk(fault_pd, 1'b1, "R11", "uv masked by pgin low");
        chk(pgood_pd, 1'b0, "R11", "pgood kept while masked");
        pgin_low = 0;
        tick(N_UV - 1);
        chk(pgood_pd, 1'b0, "R11", "mask still active");
        tick(1);
        chk(pgood_pd, 1'b1, "R11", "uv drops pgood when unmasked");
        chk(fault_pd, 1'b1, "R11", "latch not yet set");
        tick(1);
        chk(fault_pd, 1'b0, "R11", "uv sets latch");
        go_off();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_debounce();
        t_pg_delay();
        t_ov_glitch();
        t_pgin_fault();
        t_pg_restart();
        for (int r = 0; r < 3; r++) t_ov(r);
        t_uv_enable();
        t_uv_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule